// File: doc/BRIEF.md
# Wake Source Flag Register

This block records which event brought a low-power controller back from sleep or display-only operation. It keeps one sticky flag for each wake source. The sources are a wake-timer expiry, a pushbutton, a serial receive line, two general-purpose pins, an optical receive path, an external reset pin, a software reset bit, an alternate reset pin that only counts while a debug-enable pin is high, a watchdog reset and a cold-start indication. After waking, the processor reads the flag vector to learn the cause.

Asynchronous pins pass through a two-stage synchroniser on the slow clock before any level or edge test. Synchronous event strobes act directly. When the internal wake level falls, which happens as the controller enters a low-power mode, every flag clears at once, so software never has to clear flags by hand. The reset-class flags clear each other, which leaves the most recent reset cause standing. A bad-supply event takes part in this cross-clearing but has no flag of its own.

Top module: `wake_flag_reg`

## Requirements
- R1: The flag vector `wakeFlags` uses this bit map: 0 timer, 1 pushbutton, 2 serial receive, 3 edge-sensitive pin, 4 level-sensitive pin, 5 optical, 6 external reset, 7 software reset, 8 alternate reset, 9 watchdog, 10 cold start. While `rstN` is low and right after it is released, only bit 10 is set.
- R2: A change on an asynchronous pin reaches its flag at the third rising clock edge after it is driven. A synchronous strobe reaches its flag at the first rising edge.
- R3: On the clock after `wakeLevel` goes from 1 to 0, every flag is cleared, except any flag whose set condition is present in that same cycle.
- R4: The timer flag sets on a `timerExpire` pulse. The pushbutton flag and the level-pin flag set while their pins are high.
- R5: The serial receive flag sets on either edge of its pin. The edge-pin flag sets on a rising edge only, and a falling edge has no effect.
- R6: With `optLevelSel`=1 the optical flag sets on a high level of `optSharedPin`, and edges on `optRxPin` are ignored. With `optLevelSel`=0 it sets on either edge of `optRxPin`, and `optSharedPin` is ignored.
- R7: The alternate reset flag sets only while `altRstPin` and `debugEnPin` are both high.
- R8: The external reset flag clears when the cold-start, software reset or watchdog flag sets, or when a bad-supply event occurs.
- R9: The software reset flag clears on a set of the cold-start, watchdog or external reset flag, or on a bad-supply event. The watchdog flag clears on a set of the cold-start, software reset or external reset flag, or on a bad-supply event.
- R10: The cold-start flag clears on a set of the software reset, watchdog or external reset flag, or on a bad-supply event. The alternate reset flag clears on a set of the cold-start, external reset, watchdog or software reset flag, and a bad-supply event leaves it alone.
- R11: If a flag's set condition and one of its clear conditions happen in the same cycle, the flag ends up set.
- R12: With no set and no clear condition, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow (32 kHz class) clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| wakeLevel | input | 1 | Internal wake level; its falling edge clears the flags |
| timerExpire | input | 1 | Synchronous wake-timer expiry strobe |
| pushBtnPin | input | 1 | Asynchronous pushbutton pin, level-sensitive |
| serRxPin | input | 1 | Asynchronous serial receive pin, either edge |
| gpioEdgePin | input | 1 | Asynchronous general-purpose pin, rising edge |
| gpioLevelPin | input | 1 | Asynchronous general-purpose pin, high level |
| optRxPin | input | 1 | Asynchronous optical receive input, either edge |
| optSharedPin | input | 1 | Asynchronous shared pin used in optical level mode |
| optLevelSel | input | 1 | Optical mode select: 1 level on shared pin, 0 edges on receive input |
| extRstPin | input | 1 | Asynchronous external reset pin |
| swRstBit | input | 1 | Synchronous software reset request |
| altRstPin | input | 1 | Asynchronous alternate reset pin |
| debugEnPin | input | 1 | Asynchronous debug-enable pin gating the alternate reset |
| watchdogRst | input | 1 | Synchronous watchdog reset strobe |
| coldStartEvt | input | 1 | Synchronous cold-start strobe |
| badSupplyEvt | input | 1 | Synchronous bad-supply strobe, clears reset-class flags |
| wakeFlags | output | 11 | Sticky wake flag vector (bit map in R1) |

## Verification
The bench pulses the timer strobe while the wake level falls and holds a level pin high across the same clear. A design that lets the clear win would lose both causes. It drives the falling edge of the rising-edge pin and toggles each optical input in the mode that should ignore it. Logic that mixes up edge and level tests, or that decodes the option bit the wrong way round, would raise a flag that should stay clear. The bench walks a chain of reset-class events in which each one should knock out the flag before it. It also checks that a bad-supply event spares the alternate reset flag and that two simultaneous reset causes both stay set. A wrong cross-clear table would leave a stale cause standing or erase a fresh one. Latency is checked one cycle before and at the third edge, so a synchroniser with the wrong depth shows up.

// File: rtl/wake_flag_pkg.sv
package wake_flag_pkg;

  localparam int NUM_FLAGS = 11;

  // flag bit positions (read by software)
  localparam int FLAG_TMR  = 0;
  localparam int FLAG_PB   = 1;
  localparam int FLAG_RX   = 2;
  localparam int FLAG_GPE  = 3;
  localparam int FLAG_GPL  = 4;
  localparam int FLAG_OPT  = 5;
  localparam int FLAG_EXT  = 6;
  localparam int FLAG_SW   = 7;
  localparam int FLAG_ALT  = 8;
  localparam int FLAG_WD   = 9;
  localparam int FLAG_COLD = 10;

  // synchronised pin lanes
  localparam int NUM_PINS  = 9;
  localparam int PIN_PB    = 0;
  localparam int PIN_RX    = 1;
  localparam int PIN_GPE   = 2;
  localparam int PIN_GPL   = 3;
  localparam int PIN_OPTRX = 4;
  localparam int PIN_OPTSH = 5;
  localparam int PIN_EXT   = 6;
  localparam int PIN_ALT   = 7;
  localparam int PIN_DBG   = 8;

  typedef logic [NUM_FLAGS-1:0] flagVec_t;

  typedef struct packed {
    flagVec_t setVec;
    flagVec_t clrVec;
    logic     wakeFall;
  } flagStrobe_t;

  function automatic flagVec_t bitOf(int idx);
    return flagVec_t'(1) << idx;
  endfunction

  localparam flagVec_t FLAG_RESET_VALUE = flagVec_t'(1) << FLAG_COLD;

  // flags cleared by a bad-supply event
  localparam flagVec_t BAD_SUPPLY_CLEARS =
      (flagVec_t'(1) << FLAG_EXT) | (flagVec_t'(1) << FLAG_SW) |
      (flagVec_t'(1) << FLAG_WD)  | (flagVec_t'(1) << FLAG_COLD);

  // which flag-set events clear flag idx
  function automatic flagVec_t crossClearSources(int idx);
    flagVec_t m;
    m = '0;
    case (idx)
      FLAG_EXT:  m = bitOf(FLAG_COLD) | bitOf(FLAG_SW)  | bitOf(FLAG_WD);
      FLAG_SW:   m = bitOf(FLAG_COLD) | bitOf(FLAG_WD)  | bitOf(FLAG_EXT);
      FLAG_WD:   m = bitOf(FLAG_COLD) | bitOf(FLAG_SW)  | bitOf(FLAG_EXT);
      FLAG_COLD: m = bitOf(FLAG_SW)   | bitOf(FLAG_WD)  | bitOf(FLAG_EXT);
      FLAG_ALT:  m = bitOf(FLAG_COLD) | bitOf(FLAG_EXT) | bitOf(FLAG_WD) | bitOf(FLAG_SW);
      default:   m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/wake_pin_sync.sv
module wake_pin_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinAsync,
  output logic [WIDTH-1:0] pinSync
);

  localparam int LAST = STAGES - 1;

  for (genvar p = 0; p < WIDTH; p++) begin : gLane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], pinAsync[p]};
    end
    assign pinSync[p] = chain[LAST];
  end

endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
  import wake_flag_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinSync,
  input  logic                wakeLevel,
  input  logic                timerExpire,
  input  logic                optLevelSel,
  input  logic                swRstBit,
  input  logic                watchdogRst,
  input  logic                coldStartEvt,
  input  logic                badSupplyEvt,
  output flagStrobe_t         strb
);

  logic [NUM_PINS-1:0] pinPrev;
  logic [NUM_PINS-1:0] pinRise;
  logic [NUM_PINS-1:0] pinToggle;
  logic                wakePrev;
  logic                wakeFall;
  flagVec_t            setVec;
  flagVec_t            clrVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrev  <= '0;
      wakePrev <= 1'b0;
    end else begin
      pinPrev  <= pinSync;
      wakePrev <= wakeLevel;
    end
  end

  assign pinRise   = pinSync & ~pinPrev;
  assign pinToggle = pinSync ^ pinPrev;
  assign wakeFall  = wakePrev & ~wakeLevel;

  always_comb begin
    setVec            = '0;
    setVec[FLAG_TMR]  = timerExpire;
    setVec[FLAG_PB]   = pinSync[PIN_PB];
    setVec[FLAG_RX]   = pinToggle[PIN_RX];
    setVec[FLAG_GPE]  = pinRise[PIN_GPE];
    setVec[FLAG_GPL]  = pinSync[PIN_GPL];
    setVec[FLAG_OPT]  = optLevelSel ? pinSync[PIN_OPTSH] : pinToggle[PIN_OPTRX];
    setVec[FLAG_EXT]  = pinSync[PIN_EXT];
    setVec[FLAG_SW]   = swRstBit;
    setVec[FLAG_ALT]  = pinSync[PIN_ALT] & pinSync[PIN_DBG];
    setVec[FLAG_WD]   = watchdogRst;
    setVec[FLAG_COLD] = coldStartEvt;
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : gClr
    localparam flagVec_t SRC = crossClearSources(f);
    localparam logic BADHIT = BAD_SUPPLY_CLEARS[f];
    assign clrVec[f] = wakeFall | (|(setVec & SRC)) | (BADHIT & badSupplyEvt);
  end

  always_comb begin
    strb.setVec   = setVec;
    strb.clrVec   = clrVec;
    strb.wakeFall = wakeFall;
  end

  // R7: alternate reset only counts while debug enable is seen high
  assert_alt_needs_debug_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.setVec[FLAG_ALT] |-> pinSync[PIN_DBG]);

  // R9: a cold-start set must raise the watchdog clear unless watchdog sets too
  assert_cold_clears_wd_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setVec[FLAG_COLD] && !strb.setVec[FLAG_WD]) |-> strb.clrVec[FLAG_WD]);

endmodule

// File: rtl/wake_flag_datapath.sv
module wake_flag_datapath
  import wake_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  flagStrobe_t strb,
  output flagVec_t    flags
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= FLAG_RESET_VALUE;
    else       flags <= strb.setVec | (flags & ~strb.clrVec);
  end

  // R3: a wake fall with no competing set empties the vector
  assert_wake_fall_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wakeFall && strb.setVec == '0) |=> (flags == '0));

  // R11: every requested set is visible on the next cycle
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setVec != '0) |=> ((flags & $past(strb.setVec)) == $past(strb.setVec)));

  // R12: quiet cycles hold the flags
  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setVec == '0 && strb.clrVec == '0) |=> $stable(flags));

  // R8: software reset knocks out the external reset flag
  assert_ext_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setVec[FLAG_SW] && !strb.setVec[FLAG_EXT]) |=> !flags[FLAG_EXT]);

  // R10: software reset knocks out the alternate reset flag
  assert_alt_cleared_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setVec[FLAG_SW] && !strb.setVec[FLAG_ALT]) |=> !flags[FLAG_ALT]);

endmodule

// File: rtl/wake_flag_reg.sv
module wake_flag_reg
  import wake_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wakeLevel,
  input  logic                 timerExpire,
  input  logic                 pushBtnPin,
  input  logic                 serRxPin,
  input  logic                 gpioEdgePin,
  input  logic                 gpioLevelPin,
  input  logic                 optRxPin,
  input  logic                 optSharedPin,
  input  logic                 optLevelSel,
  input  logic                 extRstPin,
  input  logic                 swRstBit,
  input  logic                 altRstPin,
  input  logic                 debugEnPin,
  input  logic                 watchdogRst,
  input  logic                 coldStartEvt,
  input  logic                 badSupplyEvt,
  output logic [NUM_FLAGS-1:0] wakeFlags
);

  logic [NUM_PINS-1:0] pinAsync;
  logic [NUM_PINS-1:0] pinSync;
  flagStrobe_t         strb;

  always_comb begin
    pinAsync            = '0;
    pinAsync[PIN_PB]    = pushBtnPin;
    pinAsync[PIN_RX]    = serRxPin;
    pinAsync[PIN_GPE]   = gpioEdgePin;
    pinAsync[PIN_GPL]   = gpioLevelPin;
    pinAsync[PIN_OPTRX] = optRxPin;
    pinAsync[PIN_OPTSH] = optSharedPin;
    pinAsync[PIN_EXT]   = extRstPin;
    pinAsync[PIN_ALT]   = altRstPin;
    pinAsync[PIN_DBG]   = debugEnPin;
  end

  wake_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .pinAsync (pinAsync),
    .pinSync  (pinSync)
  );

  wake_event_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .pinSync      (pinSync),
    .wakeLevel    (wakeLevel),
    .timerExpire  (timerExpire),
    .optLevelSel  (optLevelSel),
    .swRstBit     (swRstBit),
    .watchdogRst  (watchdogRst),
    .coldStartEvt (coldStartEvt),
    .badSupplyEvt (badSupplyEvt),
    .strb         (strb)
  );

  wake_flag_datapath uData (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .flags (wakeFlags)
  );

endmodule

// File: tb/tb_wake_flag_reg.sv
module tb_wake_flag_reg;

  localparam int NF = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakeLevel = 1'b1;
  logic timerExpire = 1'b0, pushBtnPin = 1'b0, serRxPin = 1'b0;
  logic gpioEdgePin = 1'b0, gpioLevelPin = 1'b0, optRxPin = 1'b0;
  logic optSharedPin = 1'b0, optLevelSel = 1'b0, extRstPin = 1'b0;
  logic swRstBit = 1'b0, altRstPin = 1'b0, debugEnPin = 1'b0;
  logic watchdogRst = 1'b0, coldStartEvt = 1'b0, badSupplyEvt = 1'b0;
  logic [NF-1:0] wakeFlags;

  int cycleCount = 0;
  int checks = 0;
  int errors = 0;

  int          cycQ[$];
  logic [NF-1:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cycleCount <= cycleCount + 1;

  wake_flag_reg dut (
    .clk(clk), .rstN(rstN), .wakeLevel(wakeLevel), .timerExpire(timerExpire),
    .pushBtnPin(pushBtnPin), .serRxPin(serRxPin), .gpioEdgePin(gpioEdgePin),
    .gpioLevelPin(gpioLevelPin), .optRxPin(optRxPin), .optSharedPin(optSharedPin),
    .optLevelSel(optLevelSel), .extRstPin(extRstPin), .swRstBit(swRstBit),
    .altRstPin(altRstPin), .debugEnPin(debugEnPin), .watchdogRst(watchdogRst),
    .coldStartEvt(coldStartEvt), .badSupplyEvt(badSupplyEvt), .wakeFlags(wakeFlags)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    if (cycQ.size() > 0) begin
      if (cycQ[0] == cycleCount) begin
        checks++;
        if (wakeFlags !== expQ[0]) begin
          errors++;
          $display("FAIL %s flags=%h expected=%h", tagQ[0], wakeFlags, expQ[0]);
        end
        void'(cycQ.pop_front()); void'(expQ.pop_front()); void'(tagQ.pop_front());
      end else if (cycQ[0] < cycleCount) begin
        checks++; errors++;
        $display("FAIL %s missed sample actual=%h expected=%h", tagQ[0], wakeFlags, expQ[0]);
        void'(cycQ.pop_front()); void'(expQ.pop_front()); void'(tagQ.pop_front());
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expectAt(int lat, logic [NF-1:0] v, string tag);
    cycQ.push_back(cycleCount + lat);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  // R3: drop the wake level for one cycle
  task automatic wakeDrop(logic [NF-1:0] keep, string tag);
    wakeLevel = 1'b0;
    expectAt(1, keep, tag);
    tick(1);
    wakeLevel = 1'b1;
    tick(2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=done", wakeFlags);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    expectAt(0, 11'h400, "R1 in reset");
    tick(1);
    rstN = 1'b1;
    expectAt(1, 11'h400, "R1 after reset");
    tick(3);
    wakeDrop(11'h000, "R3 clear cold");

    // R4 timer strobe, R2 one-edge latency
    timerExpire = 1'b1;
    expectAt(1, 11'h001, "R4 R2 timer");
    tick(1);
    timerExpire = 1'b0;
    tick(3);
    expectAt(1, 11'h001, "R12 sticky timer");
    tick(2);

    // R4 pushbutton level, R2 three-edge latency
    pushBtnPin = 1'b1;
    expectAt(2, 11'h001, "R2 pin not yet");
    expectAt(3, 11'h003, "R2 R4 pushbutton");
    tick(3);
    pushBtnPin = 1'b0;
    tick(5);

    // R4 level pin, then R11 set beats wake fall clear
    gpioLevelPin = 1'b1;
    expectAt(3, 11'h013, "R4 level pin");
    tick(4);
    timerExpire = 1'b1;
    wakeDrop(11'h011, "R11 set wins over wake fall");
    timerExpire = 1'b0;
    gpioLevelPin = 1'b0;
    tick(5);
    wakeDrop(11'h000, "R3 clear");

    // R5 edge pin: rising sets, falling ignored
    gpioEdgePin = 1'b1;
    expectAt(3, 11'h008, "R5 rise");
    tick(5);
    wakeDrop(11'h000, "R3 clear");
    gpioEdgePin = 1'b0;
    expectAt(3, 11'h000, "R5 fall ignored");
    expectAt(4, 11'h000, "R5 fall ignored late");
    tick(5);

    // R5 serial receive: both edges
    serRxPin = 1'b1;
    expectAt(3, 11'h004, "R5 rx rise");
    tick(5);
    wakeDrop(11'h000, "R3 clear");
    serRxPin = 1'b0;
    expectAt(3, 11'h004, "R5 rx fall");
    tick(5);
    wakeDrop(11'h000, "R3 clear");

    // R6 optical in level mode
    optLevelSel = 1'b1;
    optRxPin = 1'b1;
    expectAt(4, 11'h000, "R6 edge ignored in level mode");
    tick(5);
    optRxPin = 1'b0;
    tick(5);
    optSharedPin = 1'b1;
    expectAt(3, 11'h020, "R6 shared level");
    tick(4);
    optSharedPin = 1'b0;
    tick(5);
    wakeDrop(11'h000, "R3 clear");

    // R6 optical in edge mode
    optLevelSel = 1'b0;
    optSharedPin = 1'b1;
    expectAt(4, 11'h000, "R6 shared ignored in edge mode");
    tick(5);
    optRxPin = 1'b1;
    expectAt(3, 11'h020, "R6 rx rise");
    tick(5);
    wakeDrop(11'h000, "R3 clear");
    optRxPin = 1'b0;
    expectAt(3, 11'h020, "R6 rx fall");
    tick(5);
    optSharedPin = 1'b0;
    tick(3);
    wakeDrop(11'h000, "R3 clear");

    // R7 alternate reset gated by debug enable
    altRstPin = 1'b1;
    expectAt(4, 11'h000, "R7 gated off");
    tick(5);
    debugEnPin = 1'b1;
    expectAt(3, 11'h100, "R7 gated on");
    tick(4);
    altRstPin = 1'b0;
    debugEnPin = 1'b0;
    tick(5);

    // reset-class chain
    swRstBit = 1'b1;
    expectAt(1, 11'h080, "R10 sw clears alt");
    tick(1);
    swRstBit = 1'b0;
    tick(2);
    extRstPin = 1'b1;
    expectAt(3, 11'h040, "R9 ext clears sw");
    tick(3);
    extRstPin = 1'b0;
    tick(5);
    watchdogRst = 1'b1;
    expectAt(1, 11'h200, "R8 wd clears ext");
    tick(1);
    watchdogRst = 1'b0;
    tick(2);
    coldStartEvt = 1'b1;
    expectAt(1, 11'h400, "R9 cold clears wd");
    tick(1);
    coldStartEvt = 1'b0;
    tick(2);
    badSupplyEvt = 1'b1;
    expectAt(1, 11'h000, "R10 bad clears cold");
    tick(1);
    badSupplyEvt = 1'b0;
    tick(2);

    // R10 bad supply spares alternate; external clears it
    altRstPin = 1'b1;
    debugEnPin = 1'b1;
    expectAt(3, 11'h100, "R7 alt set");
    tick(4);
    altRstPin = 1'b0;
    debugEnPin = 1'b0;
    tick(5);
    badSupplyEvt = 1'b1;
    expectAt(1, 11'h100, "R10 bad spares alt");
    tick(1);
    badSupplyEvt = 1'b0;
    tick(2);
    extRstPin = 1'b1;
    expectAt(3, 11'h040, "R10 ext clears alt");
    tick(3);
    extRstPin = 1'b0;
    tick(5);
    badSupplyEvt = 1'b1;
    expectAt(1, 11'h000, "R8 bad clears ext");
    tick(1);
    badSupplyEvt = 1'b0;
    tick(2);

    // R11 two reset causes together both stay
    swRstBit = 1'b1;
    watchdogRst = 1'b1;
    timerExpire = 1'b1;
    expectAt(1, 11'h281, "R11 simultaneous reset causes");
    tick(1);
    swRstBit = 1'b0;
    watchdogRst = 1'b0;
    timerExpire = 1'b0;
    tick(3);
    expectAt(1, 11'h281, "R12 hold");
    tick(2);
    wakeDrop(11'h000, "R3 clear many");
    tick(3);

    if (cycQ.size() != 0) begin
      errors++;
      $display("FAIL pending expectations actual=%0d expected=0", cycQ.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule